// File: doc/BRIEF.md
# Register Read-Port Allocator

This block hands out register read ports to the operands of one instruction bundle. It keeps a pool of seven numbered ports, and all of them are free when a bundle starts. Each operand request is given the lowest-numbered port that is still free. That port leaves the pool, its slot records the operand's register number, and its present bit is set. The granted index goes back to the requester in the next cycle. A data operand and a segment-id operand are treated the same way. Neither has a reserved port, so where each one lands depends only on how many ports earlier operands of the bundle have already taken.

The per-lane mask operand does not use this pool. It is stored in a field of its own with its own present bit, so a mask request succeeds even when every port is taken. When a request arrives and no port is free, the block reports an exhaustion error and changes nothing. A bundle-start pulse returns all ports to the pool and clears the slots, the present mask and the mask field.

Top module: `rport_alloc`

## Requirements
- R1: After reset all seven ports are free, every slot is 0, `present_mask` is 0, the mask field and its present bit are 0, and `rsp_valid` is 0.
- R2: A pool request (`req_valid`=1, `req_is_mask`=0) is granted the lowest-numbered free port. On the next rising edge `rsp_valid`=1, `rsp_grant`=1 and `rsp_port` holds that port index.
- R3: A grant of port p stores `req_reg` in slot p, which occupies bits [p*6 +: 6] of `slot_regs`. It also sets `present_mask` bit p+1, so port 0 sets 0x02 and port 6 sets 0x80.
- R4: Bit 0 of `present_mask` is never set by this block.
- R5: A pool request made while all seven ports are taken gives `rsp_grant`=0, `rsp_err_empty`=1 and `rsp_port`=0. The slots, `present_mask` and the pool are left unchanged.
- R6: A mask request (`req_is_mask`=1) writes `req_reg` into `mask_reg` and sets `mask_present`. It answers `rsp_grant`=1, `rsp_port`=0 and no error, and it leaves the pool, slots and `present_mask` untouched, whether or not the pool is empty.
- R7: `bundle_start` frees all ports and clears the slots, `present_mask`, `mask_reg` and `mask_present`. A request in the same cycle is served from the refilled pool, so a pool request gets port 0.
- R8: `rsp_err_port` is raised only when a port value of 7 or more reaches the slot decoder. The first-free pick never produces such a value, so it stays 0.
- R9: A cycle with `req_valid`=0 gives `rsp_valid`=0 and all response flags 0 on the next edge, and it changes no state unless `bundle_start` is high.
- R10: `rsp_grant` and `rsp_err_empty` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bundle_start | input | 1 | Refill the pool and clear all fields |
| req_valid | input | 1 | An operand request this cycle |
| req_is_mask | input | 1 | The request is the per-lane mask operand |
| req_reg | input | 6 | Register number of the operand |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_grant | output | 1 | Request was granted |
| rsp_err_empty | output | 1 | Pool was exhausted |
| rsp_err_port | output | 1 | Port value out of range at the slot decoder |
| rsp_port | output | 3 | Granted port index |
| slot_regs | output | 42 | Register number per port, port p at [p*6 +: 6] |
| present_mask | output | 8 | Port p present at bit p+1; bit 0 is 0 |
| mask_reg | output | 6 | Register number of the mask operand |
| mask_present | output | 1 | Mask field holds an operand |

## Verification
The assertions assume that the inputs are sampled only out of reset and that `req_is_mask` matters only when `req_valid` is high. They make no assumption about how often requests arrive or how many arrive per bundle. Exhaustion is treated as a legal condition to be checked, not as a misuse. The stimulus covers several cases. It fills the pool past seven requests, sends mask requests against an empty pool, and raises `bundle_start` both alone and together with a request. It then runs a long pseudo-random stretch in which `bundle_start` is rare, so that most bundles reach exhaustion.

// File: rtl/rpa_pkg.sv
`timescale 1ns/1ps
package rpa_pkg;
  // Registered response flags returned one cycle after a request.
  typedef struct packed {
    logic valid;
    logic grant;
    logic err_empty;
    logic err_port;
  } rpa_flags_t;
endpackage

// File: rtl/rpa_pick.sv
`timescale 1ns/1ps
// Lowest-index-first selection over a free vector.
module rpa_pick #(
  parameter int N  = 7,
  parameter int IW = 3
) (
  input  logic [N-1:0]  free_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  function automatic logic [IW-1:0] first_free(input logic [N-1:0] f);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (f[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign any_o = |free_i;
  assign idx_o = first_free(free_i);
endmodule

// File: rtl/rpa_slots.sv
`timescale 1ns/1ps
// Per-port register-number slots with present bits at port+1.
module rpa_slots #(
  parameter int N  = 7,
  parameter int RW = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_port_i,
  input  logic [RW-1:0] wr_reg_i,
  output logic [N*RW-1:0] slots_o,
  output logic [N:0]    present_o,
  output logic          bad_port_o
);
  logic [N-1:0] pres_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [RW-1:0] slot_q;
    logic          hit;
    assign hit = wr_en_i && (wr_port_i == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q    <= '0;
        pres_q[g] <= 1'b0;
      end else if (hit) begin
        slot_q    <= wr_reg_i;
        pres_q[g] <= 1'b1;
      end else if (clr_i) begin
        slot_q    <= '0;
        pres_q[g] <= 1'b0;
      end
    end
    assign slots_o[g*RW +: RW] = slot_q;
  end

  // Bit 0 belongs to another field and is never driven high here.
  assign present_o  = {pres_q, 1'b0};
  assign bad_port_o = wr_en_i && (wr_port_i >= IW'(N));
endmodule

// File: rtl/rport_alloc.sv
`timescale 1ns/1ps
module rport_alloc #(
  parameter int NPORT = 7,
  parameter int REG_W = 6,
  localparam int IW   = $clog2(NPORT + 1),
  localparam int MW   = NPORT + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bundle_start,
  input  logic               req_valid,
  input  logic               req_is_mask,
  input  logic [REG_W-1:0]   req_reg,
  output logic               rsp_valid,
  output logic               rsp_grant,
  output logic               rsp_err_empty,
  output logic               rsp_err_port,
  output logic [IW-1:0]      rsp_port,
  output logic [NPORT*REG_W-1:0] slot_regs,
  output logic [MW-1:0]      present_mask,
  output logic [REG_W-1:0]   mask_reg,
  output logic               mask_present
);
  import rpa_pkg::*;

  logic [NPORT-1:0] free_q;
  logic [NPORT-1:0] free_eff;
  logic             any_free;
  logic [IW-1:0]    pick_idx;
  logic             pool_req;
  logic             take;
  logic             pool_empty_hit;
  logic             bad_port;
  rpa_flags_t       flags_q;
  logic [IW-1:0]    port_q;

  assign free_eff       = bundle_start ? {NPORT{1'b1}} : free_q;
  assign pool_req       = req_valid && !req_is_mask;
  assign take           = pool_req && any_free;
  assign pool_empty_hit = pool_req && !any_free;

  rpa_pick #(.N(NPORT), .IW(IW)) pick_i (
    .free_i (free_eff),
    .any_o  (any_free),
    .idx_o  (pick_idx)
  );

  rpa_slots #(.N(NPORT), .RW(REG_W), .IW(IW)) slots_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (bundle_start),
    .wr_en_i    (take),
    .wr_port_i  (pick_idx),
    .wr_reg_i   (req_reg),
    .slots_o    (slot_regs),
    .present_o  (present_mask),
    .bad_port_o (bad_port)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= {NPORT{1'b1}};
    end else if (bundle_start || take) begin
      free_q <= take ? (free_eff & ~(NPORT'(1) << pick_idx)) : free_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_reg     <= '0;
      mask_present <= 1'b0;
    end else if (req_valid && req_is_mask) begin
      mask_reg     <= req_reg;
      mask_present <= 1'b1;
    end else if (bundle_start) begin
      mask_reg     <= '0;
      mask_present <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      port_q  <= '0;
    end else begin
      flags_q.valid     <= req_valid;
      flags_q.grant     <= take || (req_valid && req_is_mask);
      flags_q.err_empty <= pool_empty_hit;
      flags_q.err_port  <= bad_port;
      port_q            <= take ? pick_idx : '0;
    end
  end

  assign rsp_valid     = flags_q.valid;
  assign rsp_grant     = flags_q.grant;
  assign rsp_err_empty = flags_q.err_empty;
  assign rsp_err_port  = flags_q.err_port;
  assign rsp_port      = port_q;
endmodule

// File: rtl/rport_alloc_chk.sv
`timescale 1ns/1ps
module rport_alloc_chk #(
  parameter int NPORT = 7,
  parameter int IW    = 3,
  parameter int MW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bundle_start,
  input logic             req_valid,
  input logic             req_is_mask,
  input logic             rsp_valid,
  input logic             rsp_grant,
  input logic             rsp_err_empty,
  input logic             rsp_err_port,
  input logic [IW-1:0]    rsp_port,
  input logic [MW-1:0]    present_mask,
  input logic [NPORT-1:0] free_q
);
  // R2
  lowest_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_grant && !$past(req_is_mask) && !$past(bundle_start)) |->
    ((($past(present_mask) >> 1) & ((MW'(1) << rsp_port) - MW'(1))) ==
     ((MW'(1) << rsp_port) - MW'(1))));

  // R3
  present_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_grant && !$past(req_is_mask)) |-> present_mask[rsp_port + 1]);

  // R3
  pool_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(present_mask) + $countones(free_q)) == NPORT);

  // R4
  bit_zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !present_mask[0]);

  // R5
  empty_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_empty |-> (!rsp_grant && $stable(present_mask) && rsp_port == '0));

  // R7
  bundle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle_start && !(req_valid && !req_is_mask)) |=> present_mask == '0);

  // R8
  no_bad_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_err_port);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_grant || rsp_err_empty));

  // R10
  grant_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_grant, rsp_err_empty}));
endmodule

bind rport_alloc rport_alloc_chk #(.NPORT(NPORT), .IW(IW), .MW(MW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bundle_start  (bundle_start),
  .req_valid     (req_valid),
  .req_is_mask   (req_is_mask),
  .rsp_valid     (rsp_valid),
  .rsp_grant     (rsp_grant),
  .rsp_err_empty (rsp_err_empty),
  .rsp_err_port  (rsp_err_port),
  .rsp_port      (rsp_port),
  .present_mask  (present_mask),
  .free_q        (free_q)
);

// File: tb/rport_alloc_tb_top.sv
`timescale 1ns/1ps
module rport_alloc_tb_top;
  localparam int NP = 7;
  localparam int RW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bundle_start = 1'b0;
  logic req_valid = 1'b0;
  logic req_is_mask = 1'b0;
  logic [RW-1:0] req_reg = '0;
  logic rsp_valid, rsp_grant, rsp_err_empty, rsp_err_port;
  logic [2:0] rsp_port;
  logic [NP*RW-1:0] slot_regs;
  logic [7:0] present_mask;
  logic [RW-1:0] mask_reg;
  logic mask_present;

  always #2.5 clk = ~clk;

  rport_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .bundle_start(bundle_start),
    .req_valid(req_valid), .req_is_mask(req_is_mask), .req_reg(req_reg),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_err_empty(rsp_err_empty),
    .rsp_err_port(rsp_err_port), .rsp_port(rsp_port), .slot_regs(slot_regs),
    .present_mask(present_mask), .mask_reg(mask_reg), .mask_present(mask_present)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state
  bit m_free [NP];
  int m_slot [NP];
  int m_mreg;
  bit m_mpres;
  bit e_valid, e_grant, e_err;
  int e_port;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_mask();
    int m = 0;
    for (int p = 0; p < NP; p++) if (!m_free[p]) m |= (1 << (p + 1));
    return m;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin m_free[p] = 1; m_slot[p] = 0; end
    m_mreg = 0; m_mpres = 0;
    e_valid = 0; e_grant = 0; e_err = 0; e_port = 0;
  endtask

  task automatic compare_all(input string ctx);
    chk({"R9 rsp_valid ", ctx}, int'(rsp_valid), int'(e_valid));
    chk({"R2 rsp_grant ", ctx}, int'(rsp_grant), int'(e_grant));
    chk({"R2 rsp_port ", ctx}, int'(rsp_port), e_port);
    chk({"R5 rsp_err_empty ", ctx}, int'(rsp_err_empty), int'(e_err));
    chk({"R8 rsp_err_port ", ctx}, int'(rsp_err_port), 0);
    chk({"R3 present_mask ", ctx}, int'(present_mask), model_mask());
    chk({"R4 present bit0 ", ctx}, int'(present_mask[0]), 0);
    for (int p = 0; p < NP; p++)
      chk({"R3 slot ", ctx}, int'(slot_regs[p*RW +: RW]), m_slot[p]);
    chk({"R6 mask_reg ", ctx}, int'(mask_reg), m_mreg);
    chk({"R6 mask_present ", ctx}, int'(mask_present), int'(m_mpres));
    chk({"R10 grant/err exclusive ", ctx}, int'(rsp_grant && rsp_err_empty), 0);
  endtask

  task automatic step(input bit bs, input bit v, input bit ism, input int rg, input string ctx);
    int found;
    @(negedge clk);
    bundle_start = bs; req_valid = v; req_is_mask = ism; req_reg = RW'(rg);
    if (bs) begin
      for (int p = 0; p < NP; p++) begin m_free[p] = 1; m_slot[p] = 0; end
      m_mreg = 0; m_mpres = 0;
    end
    e_valid = v; e_grant = 0; e_err = 0; e_port = 0;
    if (v) begin
      if (ism) begin
        m_mreg = rg; m_mpres = 1; e_grant = 1;
      end else begin
        found = -1;
        for (int p = 0; p < NP; p++) if (m_free[p] && found < 0) found = p;
        if (found >= 0) begin
          m_free[found] = 0; m_slot[found] = rg; e_grant = 1; e_port = found;
        end else e_err = 1;
      end
    end
    @(posedge clk);
    #1;
    compare_all(ctx);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1 reset");
    chk("R1 present after reset", int'(present_mask), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3: fill the pool in order
    for (int k = 0; k < NP; k++) step(0, 1, 0, 10 + k, "fill");
    chk("R3 port6 sets 0x80", int'(present_mask[7]), 1);
    // R5: exhaustion
    step(0, 1, 0, 33, "R5 exhausted");
    step(0, 1, 0, 34, "R5 exhausted again");
    // R6: mask with empty pool
    step(0, 1, 1, 45, "R6 mask on empty pool");
    // R9: idle
    step(0, 0, 0, 0, "R9 idle");
    // R7: bundle start alone
    step(1, 0, 0, 0, "R7 bundle clear");
    chk("R7 mask cleared", int'(mask_present), 0);
    step(0, 1, 0, 7, "R3 port0 after clear");
    chk("R3 port0 sets 0x02", int'(present_mask), 2);
    step(0, 1, 1, 9, "R6 mask keeps pool");
    step(0, 1, 0, 8, "R2 second port");
    // R7: bundle start with a same-cycle request
    step(1, 1, 0, 21, "R7 same-cycle request");
    chk("R7 same-cycle port 0", int'(rsp_port), 0);
    step(1, 1, 1, 22, "R7 same-cycle mask");

    for (int k = 0; k < 400; k++) begin
      int r = $urandom % 100;
      step(r < 6, ($urandom % 4) != 0, ($urandom % 8) == 0, $urandom % 64, "random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule